// File: doc/BRIEF.md
# Shadowed PWM Match Register Bank

This block keeps a set of PWM compare values, each stored twice: a shadow copy that the register bus writes, and an active copy that the period counter and downstream edge logic actually use. When the block runs in shadowed mode, software can rewrite any compare value mid-period without disturbing the waveform. A separate arm register marks which channels should take their new value. The hand-over happens only at the period boundary.

The period boundary is the cycle in which the free-running period counter equals the active value of channel 0. On that clock edge, three things happen together. The counter returns to zero. Every armed channel copies its shadow into its active register. All arm bits clear. Several channels armed by one write therefore change on the same edge, whatever order their shadows were written in. In direct mode, a write lands in both copies at once, which lets software set up the initial values.

The block gives out the active values, the counter, one equal pulse per channel and a period pulse, for use by the PWM edge logic that sits next to it.

Top module: `pwm_match_bank`

## Requirements
- R1: After reset, the counter, every shadow copy, every active copy and the arm register are zero, and `match_eq_o` and `period_evt_o` are low.
- R2: With `pwm_mode_i` low, a write to channel address i (0 to NUM_MATCH-1) updates both the shadow and the active value of channel i on that clock edge.
- R3: With `pwm_mode_i` high, a write to channel address i updates only the shadow copy. A read of address i returns the shadow copy, and `active_o` does not change except at a period boundary.
- R4: The arm register sits at address 2**ADDR_W-1 (15 by default), with bit i arming channel i. A write ORs the low NUM_MATCH data bits into it, so writing zero has no effect. Data bits at NUM_MATCH and above (bit 7 by default) are ignored, and they read back as 0.
- R5: At a period boundary, every channel whose arm bit is set copies its shadow into its active register. Unarmed channels keep their active value.
- R6: After a period boundary, every arm bit that was set before the boundary reads 0.
- R7: An arm write in the same cycle as a period boundary is not lost. Its bits stay pending until the next boundary.
- R8: With `cnt_en_i` high, the counter increments on each clock. When it equals the active channel-0 value, it returns to 0 on the next clock and `period_evt_o` is high for that cycle. With `cnt_en_i` low, the counter holds.
- R9: `match_eq_o[i]` is high exactly when `cnt_en_i` is high and the counter equals the active value of channel i.
- R10: Channels armed together take their new values on the same edge. A new channel-0 value sets the length of the period that starts right after that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_mode_i | input | 1 | 1: shadowed writes; 0: direct writes |
| cnt_en_i | input | 1 | Counter advance enable |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | CNT_W | Write data |
| we_i | input | 1 | Write strobe |
| rdata_o | output | CNT_W | Read data for `addr_i` (shadow value or arm bits) |
| count_o | output | CNT_W | Period counter |
| active_o | output | NUM_MATCH x CNT_W | Active compare values, packed |
| match_eq_o | output | NUM_MATCH | Per-channel equal pulse |
| period_evt_o | output | 1 | Period boundary pulse |

## Verification
The bench builds the block with its default parameters: seven channels, a 32-bit counter and a 4-bit address. With these values, the reserved arm bit 7 is a real data bit that must be dropped, and the arm register sits at the top address 15. Keeping the channel-0 values small (3 to 9) gives short periods. This puts many boundaries within reach, including an arm write placed exactly on a boundary cycle and a change of the period length itself.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

   localparam int unsigned DEF_NUM_MATCH = 7;
   localparam int unsigned DEF_CNT_W     = 32;
   localparam int unsigned DEF_ADDR_W    = 4;

   typedef enum logic {
      WMODE_DIRECT = 1'b0,
      WMODE_SHADOW = 1'b1
   } wmode_e;

   // address of the arm register: top of the address space
   function automatic int unsigned arm_addr(input int unsigned addr_w);
      return (1 << addr_w) - 1;
   endfunction

endpackage

// File: rtl/pwm_bank_counter.sv
module pwm_bank_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o
);

   logic [CNT_W-1:0] cnt_q;
   logic             at_limit;

   assign at_limit = (cnt_q == limit_i);
   assign wrap_o   = en_i & at_limit;
   assign count_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (en_i) begin
         if (at_limit) cnt_q <= '0;
         else          cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/pwm_bank_arm.sv
module pwm_bank_arm #(
   parameter int unsigned N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_i,
   input  logic [N-1:0] set_bits_i,
   input  logic         evt_i,
   output logic [N-1:0] arm_o
);

   logic [N-1:0] arm_q;
   logic [N-1:0] kept;
   logic [N-1:0] added;

   // the boundary clears what was armed before it; new bits survive
   assign kept  = evt_i ? '0 : arm_q;
   assign added = set_i ? set_bits_i : '0;
   assign arm_o = arm_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q <= '0;
      else        arm_q <= kept | added;
   end

endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic             direct_i,
   input  logic [CNT_W-1:0] wdata_i,
   input  logic             commit_i,
   output logic [CNT_W-1:0] shadow_o,
   output logic [CNT_W-1:0] active_o
);

   logic [CNT_W-1:0] shadow_q;
   logic [CNT_W-1:0] active_q;

   assign shadow_o = shadow_q;
   assign active_o = active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= '0;
      end else if (wr_i) begin
         shadow_q <= wdata_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= '0;
      end else if (wr_i && direct_i) begin
         active_q <= wdata_i;
      end else if (commit_i) begin
         active_q <= shadow_q;
      end
   end

endmodule

// File: rtl/pwm_match_bank.sv
module pwm_match_bank #(
   parameter int unsigned NUM_MATCH = pwm_bank_pkg::DEF_NUM_MATCH,
   parameter int unsigned CNT_W     = pwm_bank_pkg::DEF_CNT_W,
   parameter int unsigned ADDR_W    = pwm_bank_pkg::DEF_ADDR_W
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            pwm_mode_i,
   input  logic                            cnt_en_i,
   input  logic [ADDR_W-1:0]               addr_i,
   input  logic [CNT_W-1:0]                wdata_i,
   input  logic                            we_i,
   output logic [CNT_W-1:0]                rdata_o,
   output logic [CNT_W-1:0]                count_o,
   output logic [NUM_MATCH-1:0][CNT_W-1:0] active_o,
   output logic [NUM_MATCH-1:0]            match_eq_o,
   output logic                            period_evt_o
);
   import pwm_bank_pkg::*;

   localparam int unsigned ARM_ADDR = arm_addr(ADDR_W);

   if (NUM_MATCH < 1 || NUM_MATCH > CNT_W || NUM_MATCH >= ARM_ADDR + 1) begin : g_bad_cfg
      $error("pwm_match_bank: NUM_MATCH must be 1..CNT_W and below the arm address");
   end

   wmode_e                            wmode;
   logic                              evt;
   logic                              arm_wr;
   logic [NUM_MATCH-1:0]              arm_q;
   logic [NUM_MATCH-1:0][CNT_W-1:0]   shadow;

   assign wmode  = pwm_mode_i ? WMODE_SHADOW : WMODE_DIRECT;
   assign arm_wr = we_i && (addr_i == ADDR_W'(ARM_ADDR));

   pwm_bank_counter #(.CNT_W(CNT_W)) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (cnt_en_i),
      .limit_i (active_o[0]),
      .count_o (count_o),
      .wrap_o  (evt)
   );

   assign period_evt_o = evt;

   pwm_bank_arm #(.N(NUM_MATCH)) u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (arm_wr),
      .set_bits_i (wdata_i[NUM_MATCH-1:0]),
      .evt_i      (evt),
      .arm_o      (arm_q)
   );

   for (genvar i = 0; i < NUM_MATCH; i++) begin : g_chan
      logic hit;
      assign hit = we_i && (addr_i == ADDR_W'(i));

      pwm_bank_chan #(.CNT_W(CNT_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_i     (hit),
         .direct_i (wmode == WMODE_DIRECT),
         .wdata_i  (wdata_i),
         .commit_i (evt && arm_q[i]),
         .shadow_o (shadow[i]),
         .active_o (active_o[i])
      );

      assign match_eq_o[i] = cnt_en_i && (count_o == active_o[i]);
   end

   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(ARM_ADDR)) begin
         rdata_o[NUM_MATCH-1:0] = arm_q;
      end else begin
         for (int unsigned k = 0; k < NUM_MATCH; k++) begin
            if (addr_i == ADDR_W'(k)) rdata_o = shadow[k];
         end
      end
   end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
   parameter int unsigned N      = 7,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    pwm_mode_i,
   input logic                    cnt_en_i,
   input logic [ADDR_W-1:0]       addr_i,
   input logic [CNT_W-1:0]        wdata_i,
   input logic                    we_i,
   input logic [CNT_W-1:0]        count_o,
   input logic [N-1:0][CNT_W-1:0] active_o,
   input logic [N-1:0]            match_eq_o,
   input logic                    period_evt_o,
   input logic [N-1:0]            arm
);
   localparam logic [ADDR_W-1:0] ARM_A = ADDR_W'(pwm_bank_pkg::arm_addr(ADDR_W));

   logic boundary;
   logic arm_write;
   assign boundary  = cnt_en_i && (count_o == active_o[0]);
   assign arm_write = we_i && (addr_i == ARM_A);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en_i |=> $stable(count_o));

   a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      boundary |=> (count_o == '0));

   a_r8_evt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      period_evt_o |-> match_eq_o[0]);

   a_r9_eq_then_zero: assert property (@(posedge clk) disable iff (!rst_n)
      match_eq_o[0] |=> (count_o == '0));

   a_r6_arm_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && !arm_write) |=> (arm == '0));

   a_r7_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && arm_write) |=> (arm == $past(wdata_i[N-1:0])));

   a_r3_shadow_only: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode_i && !boundary) |=> $stable(active_o));

   a_r5_unarmed_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode_i && boundary && arm == '0) |=> $stable(active_o));

endmodule

bind pwm_match_bank pwm_bank_chk #(.N(NUM_MATCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pwm_mode_i   (pwm_mode_i),
   .cnt_en_i     (cnt_en_i),
   .addr_i       (addr_i),
   .wdata_i      (wdata_i),
   .we_i         (we_i),
   .count_o      (count_o),
   .active_o     (active_o),
   .match_eq_o   (match_eq_o),
   .period_evt_o (period_evt_o),
   .arm          (arm_q)
);

// File: tb/test_pwm_match_bank.sv
module test_pwm_match_bank;
   localparam int  CLK_PERIOD = 10;
   localparam int  N  = 7;
   localparam int  W  = 32;
   localparam int  AW = 4;
   localparam logic [AW-1:0] ARM_A = 4'hF;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              pwm_mode_i = 1'b0;
   logic              cnt_en_i = 1'b0;
   logic [AW-1:0]     addr_i = '0;
   logic [W-1:0]      wdata_i = '0;
   logic              we_i = 1'b0;
   logic [W-1:0]      rdata_o;
   logic [W-1:0]      count_o;
   logic [N-1:0][W-1:0] active_o;
   logic [N-1:0]      match_eq_o;
   logic              period_evt_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwm_match_bank #(.NUM_MATCH(N), .CNT_W(W), .ADDR_W(AW)) i_pwm_match_bank (
      .clk(clk), .rst_n(rst_n), .pwm_mode_i(pwm_mode_i), .cnt_en_i(cnt_en_i),
      .addr_i(addr_i), .wdata_i(wdata_i), .we_i(we_i), .rdata_o(rdata_o),
      .count_o(count_o), .active_o(active_o), .match_eq_o(match_eq_o),
      .period_evt_o(period_evt_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
      @(negedge clk);
      addr_i = a; wdata_i = d; we_i = 1'b1;
      @(negedge clk);
      we_i = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [W-1:0] v);
      addr_i = a;
      #1;
      v = rdata_o;
   endtask

   // runs the counter up to the boundary edge; returns just after it
   task automatic run_to_boundary();
      @(negedge clk);
      cnt_en_i = 1'b1;
      #1;
      while (count_o != active_o[0]) begin
         for (int i = 0; i < N; i++)
            chk("R9", "match_eq", W'(match_eq_o[i]), W'(count_o == active_o[i]));
         @(negedge clk);
         #1;
      end
      chk("R8", "period_evt at limit", W'(period_evt_o), 1);
      @(negedge clk);
      cnt_en_i = 1'b0;
      #1;
      chk("R8", "count after wrap", count_o, 0);
   endtask

   task automatic t_reset();
      logic [W-1:0] v;
      chk("R1", "count", count_o, 0);
      for (int i = 0; i < N; i++) chk("R1", "active", active_o[i], 0);
      chk("R1", "match_eq", W'(match_eq_o), 0);
      chk("R1", "period_evt", W'(period_evt_o), 0);
      rd(ARM_A, v); chk("R1", "arm", v, 0);
      rd(4'd2, v);  chk("R1", "shadow2", v, 0);
   endtask

   task automatic t_direct();
      logic [W-1:0] v;
      pwm_mode_i = 1'b0;
      wr(4'd0, 9);
      wr(4'd3, 5);
      chk("R2", "active0", active_o[0], 9);
      chk("R2", "active3", active_o[3], 5);
      rd(4'd3, v); chk("R2", "shadow3", v, 5);
   endtask

   task automatic t_shadow();
      logic [W-1:0] v;
      pwm_mode_i = 1'b1;
      wr(4'd1, 7);
      wr(4'd2, 4);
      chk("R3", "active1 unchanged", active_o[1], 0);
      chk("R3", "active2 unchanged", active_o[2], 0);
      rd(4'd1, v); chk("R3", "shadow1 readback", v, 7);
      run_to_boundary();
      chk("R5", "unarmed active1 kept", active_o[1], 0);
      chk("R5", "unarmed active2 kept", active_o[2], 0);
   endtask

   task automatic t_arm_reg();
      logic [W-1:0] v;
      wr(ARM_A, 32'h80);
      rd(ARM_A, v); chk("R4", "reserved bit ignored", v, 0);
      wr(ARM_A, 32'h2);
      wr(ARM_A, 32'h4);
      rd(ARM_A, v); chk("R4", "OR merge", v, 32'h6);
      wr(ARM_A, 32'h0);
      rd(ARM_A, v); chk("R4", "zero write no effect", v, 32'h6);
      chk("R3", "armed active1 before boundary", active_o[1], 0);
      run_to_boundary();
      chk("R10", "active1 same edge", active_o[1], 7);
      chk("R10", "active2 same edge", active_o[2], 4);
      chk("R5", "active0 unarmed", active_o[0], 9);
      rd(ARM_A, v); chk("R6", "arm cleared", v, 0);
   endtask

   task automatic t_pending();
      logic [W-1:0] v;
      wr(4'd3, 11);
      @(negedge clk);
      cnt_en_i = 1'b1;
      #1;
      while (count_o != active_o[0]) begin
         @(negedge clk);
         #1;
      end
      addr_i = ARM_A; wdata_i = 32'h8; we_i = 1'b1;
      @(negedge clk);
      we_i = 1'b0; cnt_en_i = 1'b0;
      #1;
      chk("R8", "wrapped", count_o, 0);
      chk("R7", "active3 not yet", active_o[3], 5);
      rd(ARM_A, v); chk("R7", "arm pending", v, 32'h8);
      run_to_boundary();
      chk("R7", "active3 next boundary", active_o[3], 11);
      rd(ARM_A, v); chk("R6", "arm cleared again", v, 0);
   endtask

   task automatic t_period();
      logic [W-1:0] v;
      wr(4'd0, 3);
      wr(ARM_A, 32'h1);
      run_to_boundary();
      chk("R10", "active0 new", active_o[0], 3);
      @(negedge clk);
      cnt_en_i = 1'b1;
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         #1;
         chk("R8", "count step", count_o, W'(k));
         chk("R8", "evt", W'(period_evt_o), W'(k == 3));
      end
      @(negedge clk);
      #1;
      chk("R10", "short period wrap", count_o, 0);
      cnt_en_i = 1'b0;
      v = count_o;
      repeat (3) @(negedge clk);
      #1;
      chk("R8", "hold when disabled", count_o, v);
      chk("R9", "eq low when disabled", W'(match_eq_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_direct();
      t_shadow();
      t_arm_reg();
      t_pending();
      t_period();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            #(CLK_PERIOD * 20000);
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule